// File: doc/BRIEF.md
# Slow-Clock Register Write Synchronizer

This block sits between a fast host register bus and a real-time-clock timing domain that changes state only on a slow tick. Each host write to one of the clock's synchronized registers (control, time, alarm) is caught in a single shadow slot. The write is committed to the register bank on the next synchronization tick, not on the bus cycle that carried it. While a commit is outstanding the slot is full. Any further synchronized write arriving in that window is dropped without notice, and the earlier write commits unchanged. Software is expected to poll the pending flag before it issues the next write, or to wait for the completion event.

The status register takes a different path. Its write-one-to-clear bits act on the very next bus cycle, and writing it never fills the shadow slot. The status word carries a completion flag, which is sticky until cleared, a live pending flag, and a few sticky event flags set by pulses from the timing domain. An interrupt line reports completion when the committed control register enables it.

Both tick sources arrive as single-cycle strobes already in the bus clock domain. Bit 0 of the committed control register picks between them: set selects the slow (1 Hz) strobe, clear selects the raw 32.768 kHz strobe. The write bus has no ready signal and is never back-pressured. A write that cannot be taken is discarded instead. Reads are combinational and return committed state only.

Top module: `rtc_wsync`

## Requirements
- R1: After reset the control register (address 1) reads 0x1, the time (address 2) and alarm (address 3) registers read 0, the status word (address 0) reads 0, and wc_irq is low.
- R2: A write to address 1, 2 or 3 leaves the read value of that register unchanged until a selected tick arrives. The value is committed in the cycle the tick strobe is high and can be read from the next cycle.
- R3: Status bit 14 (pending) reads 1 from the cycle after an accepted synchronized write. It reads 0 from the cycle after that write commits.
- R4: A synchronized write that arrives while pending is 1 is discarded. This includes a write in the same cycle as the committing tick. The earlier value commits unchanged, and the discarded write has no later effect.
- R5: Status bit 15 (complete) reads 1 from the cycle after a commit and stays set until a status write with bit 15 set. If a commit and such a clear fall in the same cycle, the bit stays set.
- R6: A write to address 0 takes effect on the next cycle and never sets pending. Each 1 in bits 15 or 3:0 clears that bit, a 0 has no effect, and bit 14 cannot be written.
- R7: When committed control bit 0 is 1, only tick_slow commits. When it is 0, only tick_fast commits. The other strobe has no effect.
- R8: wc_irq is high exactly when status bit 15 is 1 and committed control bit 1 is 1.
- R9: A pulse on evt_in[k] sets status bit k (k = 0..3), which is sticky. If a set and a clear of the same bit fall in the same cycle, the bit stays set.
- R10: A write to an address above 3 changes no register and sets no flag. A read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | 3 | Host write address |
| wr_data | input | 32 | Host write data |
| rd_addr | input | 3 | Host read address |
| rd_data | output | 32 | Committed read data for rd_addr (combinational) |
| tick_slow | input | 1 | Single-cycle 1 Hz synchronization strobe |
| tick_fast | input | 1 | Single-cycle raw 32.768 kHz strobe |
| evt_in | input | 4 | Event pulses that set sticky status bits |
| wc_irq | output | 1 | Write-complete interrupt |

## Verification
The bench goes after overlapping writes, including one that lands in the same cycle as the committing tick. A design that queued or overwrote the slot would commit the later value, or commit a second time on the next tick. It also races a commit against a completion clear and an event pulse against its own clear. A design that let the clear win would lose a completion or an event. Last, it switches the tick source through the control register and pulses the non-selected strobe. A design that took the wrong strobe would commit early, or never. A sweep over the time and alarm registers, with varied data and idle gaps before the tick, checks that no read shows the shadow value before the commit.

// File: rtl/rtc_wsync_pkg.sv
package rtc_wsync_pkg;
  localparam int ST_CMPL_BIT   = 15;
  localparam int ST_PEND_BIT   = 14;
  localparam int CTRL_PREN_BIT = 0;
  localparam int CTRL_IE_BIT   = 1;
  localparam int ADDR_STATUS   = 0;
  localparam int SYNC_BASE     = 1;
endpackage

// File: rtl/rtc_wsync_tick_sel.sv
module rtc_wsync_tick_sel (
  input  logic pren,
  input  logic tick_slow,
  input  logic tick_fast,
  output logic sync_tick
);
  // committed prescaler enable picks the commit strobe
  always_comb sync_tick = pren ? tick_slow : tick_fast;
endmodule

// File: rtl/rtc_wsync_shadow.sv
module rtc_wsync_shadow #(
  parameter int DW = 32,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic [IW-1:0] req_idx,
  input  logic [DW-1:0] req_data,
  input  logic          sync_tick,
  output logic          pending,
  output logic          commit,
  output logic [IW-1:0] shadow_idx,
  output logic [DW-1:0] shadow_data
);
  logic accept;

  // single slot: a request is only taken while the slot is empty
  always_comb begin
    accept = req && !pending;
    commit = pending && sync_tick;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending     <= 1'b0;
      shadow_idx  <= '0;
      shadow_data <= '0;
    end else if (accept) begin
      pending     <= 1'b1;
      shadow_idx  <= req_idx;
      shadow_data <= req_data;
    end else if (commit) begin
      pending     <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_wsync_bank.sv
module rtc_wsync_bank #(
  parameter int          DW       = 32,
  parameter int          NSYNC    = 3,
  parameter int          IW       = 2,
  parameter logic [31:0] CTRL_RST = 32'h1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      commit,
  input  logic [IW-1:0]             idx,
  input  logic [DW-1:0]             data,
  output logic [NSYNC-1:0][DW-1:0]  regs_q
);
  for (genvar k = 0; k < NSYNC; k++) begin : g_reg
    localparam logic [DW-1:0] RST = (k == 0) ? DW'(CTRL_RST) : '0;
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_q[k] <= RST;
      else if (commit && idx == IW'(k))
        regs_q[k] <= data;
    end
  end
endmodule

// File: rtl/rtc_wsync_status.sv
module rtc_wsync_status #(
  parameter int DW  = 32,
  parameter int NEV = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           commit,
  input  logic           clr_cmpl,
  input  logic [NEV-1:0] clr_ev,
  input  logic [NEV-1:0] evt_in,
  input  logic           pending,
  output logic           cmpl,
  output logic [DW-1:0]  status_word
);
  import rtc_wsync_pkg::*;

  logic [NEV-1:0] ev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmpl <= 1'b0;
      ev_q <= '0;
    end else begin
      // set has priority over a same-cycle clear
      cmpl <= commit | (cmpl & ~clr_cmpl);
      ev_q <= evt_in | (ev_q & ~clr_ev);
    end
  end

  always_comb begin
    status_word              = '0;
    status_word[ST_CMPL_BIT] = cmpl;
    status_word[ST_PEND_BIT] = pending;
    status_word[NEV-1:0]     = ev_q;
  end
endmodule

// File: rtl/rtc_wsync.sv
module rtc_wsync #(
  parameter int DW    = 32,
  parameter int AW    = 3,
  parameter int NSYNC = 3,
  parameter int NEV   = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  input  logic           tick_slow,
  input  logic           tick_fast,
  input  logic [NEV-1:0] evt_in,
  output logic           wc_irq
);
  import rtc_wsync_pkg::*;

  localparam int IW = (NSYNC > 1) ? $clog2(NSYNC) : 1;

  logic                     st_wr;
  logic                     sync_wr;
  logic [IW-1:0]            wr_idx;
  logic                     pend;
  logic                     commit;
  logic                     sync_tick;
  logic [IW-1:0]            shadow_idx;
  logic [DW-1:0]            shadow_data;
  logic [NSYNC-1:0][DW-1:0] regs_q;
  logic                     cmpl;
  logic                     ie;
  logic                     pren;
  logic                     clr_cmpl;
  logic [NEV-1:0]           clr_ev;
  logic [DW-1:0]            status_word;

  // address decode
  always_comb begin
    st_wr    = wr_en && (wr_addr == AW'(ADDR_STATUS));
    sync_wr  = wr_en && (wr_addr >= AW'(SYNC_BASE)) &&
               (wr_addr <= AW'(SYNC_BASE + NSYNC - 1));
    wr_idx   = IW'(wr_addr - AW'(SYNC_BASE));
    clr_cmpl = st_wr && wr_data[ST_CMPL_BIT];
    clr_ev   = st_wr ? wr_data[NEV-1:0] : '0;
    pren     = regs_q[0][CTRL_PREN_BIT];
    ie       = regs_q[0][CTRL_IE_BIT];
  end

  rtc_wsync_tick_sel u_tick (
    .pren      (pren),
    .tick_slow (tick_slow),
    .tick_fast (tick_fast),
    .sync_tick (sync_tick)
  );

  rtc_wsync_shadow #(.DW(DW), .IW(IW)) u_shadow (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (sync_wr),
    .req_idx     (wr_idx),
    .req_data    (wr_data),
    .sync_tick   (sync_tick),
    .pending     (pend),
    .commit      (commit),
    .shadow_idx  (shadow_idx),
    .shadow_data (shadow_data)
  );

  rtc_wsync_bank #(.DW(DW), .NSYNC(NSYNC), .IW(IW), .CTRL_RST(32'h1)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .commit (commit),
    .idx    (shadow_idx),
    .data   (shadow_data),
    .regs_q (regs_q)
  );

  rtc_wsync_status #(.DW(DW), .NEV(NEV)) u_status (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit),
    .clr_cmpl    (clr_cmpl),
    .clr_ev      (clr_ev),
    .evt_in      (evt_in),
    .pending     (pend),
    .cmpl        (cmpl),
    .status_word (status_word)
  );

  // read path returns committed state only
  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(ADDR_STATUS))
      rd_data = status_word;
    for (int k = 0; k < NSYNC; k++)
      if (rd_addr == AW'(SYNC_BASE + k))
        rd_data = regs_q[k];
  end

  always_comb wc_irq = cmpl && ie;
endmodule

// File: rtl/rtc_wsync_chk.sv
module rtc_wsync_chk #(
  parameter int DW    = 32,
  parameter int NSYNC = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     pend,
  input logic                     sync_tick,
  input logic                     commit,
  input logic                     st_wr,
  input logic [DW-1:0]            wr_data,
  input logic [DW-1:0]            shadow_data,
  input logic [NSYNC-1:0][DW-1:0] regs_q,
  input logic                     cmpl,
  input logic                     ie,
  input logic                     wc_irq
);
  // R3: a pending write is gone the cycle after a selected tick
  a_r3_pend_drop: assert property (@(posedge clk) disable iff (!rst_n)
    pend && sync_tick |=> !pend);

  // R4: while pending and no tick, the slot keeps its data
  a_r4_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !sync_tick |=> pend && $stable(shadow_data));

  // R2: the committed bank only moves on a commit
  a_r2_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(regs_q));

  // R5: a commit always leaves the complete flag set
  a_r5_cmpl_set: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> cmpl);

  // R5: complete is sticky without a clear
  a_r5_cmpl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl && !(st_wr && wr_data[15]) |=> cmpl);

  // R6: status writes never fill the slot
  a_r6_st_no_pend: assert property (@(posedge clk) disable iff (!rst_n)
    !pend && st_wr |=> !pend);

  // R8: interrupt only with flag and enable
  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    wc_irq |-> cmpl && ie);
endmodule

bind rtc_wsync rtc_wsync_chk #(.DW(DW), .NSYNC(NSYNC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pend        (pend),
  .sync_tick   (sync_tick),
  .commit      (commit),
  .st_wr       (st_wr),
  .wr_data     (wr_data),
  .shadow_data (shadow_data),
  .regs_q      (regs_q),
  .cmpl        (cmpl),
  .ie          (ie),
  .wc_irq      (wc_irq)
);

// File: tb/tb_rtc_wsync.sv
module tb_rtc_wsync;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        tick_slow = 1'b0;
  logic        tick_fast = 1'b0;
  logic [3:0]  evt_in = '0;
  logic        wc_irq;

  int total = 0;
  int bad = 0;
  logic [31:0] model [4];

  rtc_wsync dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tick_slow(tick_slow), .tick_fast(tick_fast), .evt_in(evt_in),
    .wc_irq(wc_irq)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_addr = a;
    #1 v = rd_data;
  endtask

  task automatic chk_rd(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic cyc(input logic we, input logic [2:0] a, input logic [31:0] d,
                     input logic ts, input logic tf, input logic [3:0] ev);
    wr_en = we; wr_addr = a; wr_data = d;
    tick_slow = ts; tick_fast = tf; evt_in = ev;
    @(negedge clk);
    wr_en = 1'b0; tick_slow = 1'b0; tick_fast = 1'b0; evt_in = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0, 1'b0, 4'h0);
  endtask

  task automatic tslow();
    cyc(1'b0, 3'd0, 32'h0, 1'b1, 1'b0, 4'h0);
  endtask

  task automatic tfast();
    cyc(1'b0, 3'd0, 32'h0, 1'b0, 1'b1, 4'h0);
  endtask

  task automatic idle();
    cyc(1'b0, 3'd0, 32'h0, 1'b0, 1'b0, 4'h0);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] da, db;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_rd("R1 status", 3'd0, 32'h0);
    chk_rd("R1 ctrl", 3'd1, 32'h1);
    chk_rd("R1 time", 3'd2, 32'h0);
    chk_rd("R1 alarm", 3'd3, 32'h0);
    chk("R1 irq", {31'b0, wc_irq}, 32'h0);

    // R2 R3 R4 R7: deferred commit, discard, wrong strobe ignored
    wr(3'd2, 32'hA5A5_0001);
    chk_rd("R2 time before tick", 3'd2, 32'h0);
    chk_rd("R3 pend set", 3'd0, 32'h0000_4000);
    wr(3'd2, 32'hDEAD_BEEF);
    tfast();
    chk_rd("R7 fast ignored when pren=1", 3'd2, 32'h0);
    chk_rd("R3 pend held", 3'd0, 32'h0000_4000);
    tslow();
    chk_rd("R4 earlier write committed", 3'd2, 32'hA5A5_0001);
    chk_rd("R5 cmpl set pend clear", 3'd0, 32'h0000_8000);
    chk("R8 irq off when disabled", {31'b0, wc_irq}, 32'h0);
    tslow();
    chk_rd("R4 discarded write no later effect", 3'd2, 32'hA5A5_0001);

    // R5 R6 sticky complete and immediate W1C
    wr(3'd0, 32'h0000_0000);
    chk_rd("R5 cmpl sticky on zero write", 3'd0, 32'h0000_8000);
    wr(3'd0, 32'h0000_C000);
    chk_rd("R6 immediate clear, bit14 not set", 3'd0, 32'h0);

    // R8 interrupt enable
    wr(3'd1, 32'h3);
    tslow();
    chk("R8 irq on", {31'b0, wc_irq}, 32'h1);
    wr(3'd0, 32'h0000_8000);
    chk("R8 irq off after clear", {31'b0, wc_irq}, 32'h0);

    // R7 switch to raw strobe
    wr(3'd1, 32'h2);
    tslow();
    chk_rd("R7 ctrl pren cleared", 3'd1, 32'h2);
    wr(3'd0, 32'h0000_8000);
    wr(3'd3, 32'h0000_1234);
    tslow();
    chk_rd("R7 slow ignored when pren=0", 3'd3, 32'h0);
    tfast();
    chk_rd("R7 fast commits when pren=0", 3'd3, 32'h0000_1234);
    wr(3'd1, 32'h1);
    tfast();
    chk_rd("R7 ctrl restored", 3'd1, 32'h1);
    wr(3'd0, 32'h0000_8000);

    // R4 write in the same cycle as the committing tick
    wr(3'd3, 32'h0000_00D0);
    cyc(1'b1, 3'd3, 32'h0000_00E0, 1'b1, 1'b0, 4'h0);
    chk_rd("R4 tick-cycle write discarded", 3'd3, 32'h0000_00D0);
    chk_rd("R4 no pend after tick-cycle write", 3'd0, 32'h0000_8000);
    tslow();
    chk_rd("R4 no late commit", 3'd3, 32'h0000_00D0);

    // R5 commit beats a same-cycle clear
    wr(3'd0, 32'h0000_8000);
    wr(3'd2, 32'h0000_0077);
    cyc(1'b1, 3'd0, 32'h0000_8000, 1'b1, 1'b0, 4'h0);
    chk_rd("R5 set wins over clear", 3'd0, 32'h0000_8000);
    wr(3'd0, 32'h0000_8000);

    // R9 events
    cyc(1'b0, 3'd0, 32'h0, 1'b0, 1'b0, 4'h5);
    chk_rd("R9 events set", 3'd0, 32'h0000_0005);
    wr(3'd0, 32'h0000_0001);
    chk_rd("R6 event W1C", 3'd0, 32'h0000_0004);
    cyc(1'b1, 3'd0, 32'h0000_0004, 1'b0, 1'b0, 4'h4);
    chk_rd("R9 set wins over clear", 3'd0, 32'h0000_0004);
    wr(3'd0, 32'h0000_000F);
    chk_rd("R9 all cleared", 3'd0, 32'h0);

    // R10 unmapped address
    wr(3'd6, 32'hFFFF_FFFF);
    chk_rd("R10 no pend", 3'd0, 32'h0);
    tslow();
    chk_rd("R10 ctrl untouched", 3'd1, 32'h1);
    chk_rd("R10 time untouched", 3'd2, 32'h0000_0077);
    chk_rd("R10 alarm untouched", 3'd3, 32'h0000_00D0);
    chk_rd("R10 unmapped reads zero", 3'd6, 32'h0);

    // sweep over time/alarm, data patterns and gaps
    model[2] = 32'h0000_0077;
    model[3] = 32'h0000_00D0;
    for (int a = 2; a <= 3; a++) begin
      for (int p = 0; p < 8; p++) begin
        da = (32'h0101_0101 * (p + 1)) ^ (32'(a) << 20);
        db = ~da;
        wr(3'(a), da);
        for (int g = 0; g < (p % 4); g++) begin
          idle();
          chk_rd("R2 sweep unchanged in gap", 3'(a), model[a]);
        end
        wr(3'(a), db);
        chk_rd("R4 sweep unchanged after overlap", 3'(a), model[a]);
        tslow();
        model[a] = da;
        chk_rd("R2 sweep committed", 3'(a), model[a]);
        chk_rd("R3 sweep status", 3'd0, 32'h0000_8000);
        chk_rd("R4 sweep other reg kept", 3'(5 - a), model[5 - a]);
        wr(3'd0, 32'h0000_8000);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule